// File: doc/BRIEF.md
# Multi-Interval Event Timer

This block is a restartable elapsed-time source for a vending controller. The system clock runs at 1 MHz, so one cycle is one microsecond. A single up-counter runs from the last restart and drives three flags. The short flag covers the time the selected item number must be stable before the dispense strobe. The medium flag sets the width of a coin-eject pulse, which must last between 45 ms and 50 ms. The long flag sets the minimum spacing between two eject pulses, which is at least 500 ms.

The controller pulses `restart_i` and then watches the flags. Each flag goes high once its interval has passed and stays high until the next restart. The counter stops at its top value and does not wrap. The long interval is taken from the carry-out of the counter's +1 stage, so no wide comparator is needed for it. The medium threshold is compared only on the bits above its lowest set bit. A threshold with many trailing zeros, such as 46,080 cycles, therefore needs a narrow match.

Top module: `event_timer`

## Requirements
- R1: While `rst_n` is low, `short_o`, `mid_o` and `long_o` are all 0. The first clock edge after reset is released counts as the first cycle of timing, as if a restart had just been applied.
- R2: A clock edge at which `restart_i` is 1 sets all three flags to 0 and the elapsed count to 0. The flags read 0 in the cycle that follows that edge.
- R3: `short_o` becomes 1 exactly SHORT_CYC clock edges after the restarting edge, and not earlier.
- R4: `mid_o` becomes 1 exactly MID_CYC clock edges after the restarting edge, and not earlier.
- R5: `long_o` becomes 1 exactly 2^CNT_W clock edges after the restarting edge, at the edge where the counter's +1 stage carries out. It does not become 1 earlier.
- R6: Once a flag is 1, it stays 1 until a restart. The counter stops at its top value, so no flag drops when the count would wrap.
- R7: At all times, `long_o` implies `mid_o`, and `mid_o` implies `short_o`. This requires 1 <= SHORT_CYC < MID_CYC < 2^CNT_W.
- R8: While `restart_i` is held at 1, all flags stay 0.
- R9: A restart wins over a threshold reached at the same edge. The flag stays 0 and timing starts again from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (1 MHz in the target system) |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Synchronous restart of timing. Clears the count and all flags |
| short_o | output | 1 | SHORT_CYC cycles have elapsed since the last restart |
| mid_o | output | 1 | MID_CYC cycles have elapsed since the last restart |
| long_o | output | 1 | 2^CNT_W cycles have elapsed since the last restart |

## Verification
A wrong count or a wrong compare shifts the edge at which a flag rises. The bench checks every flag at every cycle of a full sweep past the top count, so such an error shows up within one cycle of the expected rise. An internal counter that wraps, or a flag register that loses its stickiness, shows up as a flag falling without a restart. The same error can also show up as a broken ordering between the flags, and this appears at the first wrap, just after 2^CNT_W cycles. A restart that is ignored or delayed leaves a flag high in the cycle after the restarting edge. This case is checked with a single restart pulse, with restart held high, and with a restart placed on a threshold edge.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // Position of the lowest set bit of v within w bits (w if v is zero).
  function automatic int unsigned low_zero_bits(input int unsigned v, input int unsigned w);
    int unsigned n;
    n = w;
    for (int unsigned i = 0; i < w; i++) begin
      if (v[i] && (n == w)) n = i;
    end
    return n;
  endfunction

endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] next_val,
  output logic             carry
);

  logic [CNT_W-1:0] count_q;

  // The +1 stage: its carry-out marks the all-ones count.
  assign {carry, next_val} = {1'b0, count_q} + {{CNT_W{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (restart) count_q <= '0;
    else if (!carry)  count_q <= next_val;
  end

endmodule

// File: rtl/evt_mark.sv
module evt_mark #(
  parameter int unsigned CNT_W  = 19,
  parameter int unsigned THRESH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] next_val,
  input  logic             carry,
  output logic             flag
);

  localparam int unsigned    LOW_Z = evt_pkg::low_zero_bits(THRESH, CNT_W);
  localparam logic [CNT_W-1:0] THR_V = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] MASK  = ~((CNT_W'(1) << LOW_Z) - CNT_W'(1));

  logic hit;

  // Only bits at and above the lowest set bit of the threshold are matched;
  // the first next-value that matches is the threshold itself.
  assign hit = ((next_val & MASK) == (THR_V & MASK)) && !carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (restart) flag <= 1'b0;
    else if (hit)     flag <= 1'b1;
  end

endmodule

// File: rtl/event_timer.sv
module event_timer #(
  parameter int unsigned CNT_W     = 19,
  parameter int unsigned SHORT_CYC = 5,
  parameter int unsigned MID_CYC   = 46080
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic short_o,
  output logic mid_o,
  output logic long_o
);

  localparam int unsigned N_MARK = 2;
  localparam int unsigned MARK_THR [N_MARK] = '{SHORT_CYC, MID_CYC};

  logic [CNT_W-1:0]  next_val;
  logic              carry;
  logic [N_MARK-1:0] marks;
  logic              long_q;

  evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart_i),
    .next_val (next_val),
    .carry    (carry)
  );

  for (genvar g = 0; g < N_MARK; g++) begin : g_mark
    evt_mark #(.CNT_W(CNT_W), .THRESH(MARK_THR[g])) u_mark (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart_i),
      .next_val (next_val),
      .carry    (carry),
      .flag     (marks[g])
    );
  end

  // Long interval: the incrementer's carry-out, latched.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         long_q <= 1'b0;
    else if (restart_i) long_q <= 1'b0;
    else if (carry)     long_q <= 1'b1;
  end

  assign short_o = marks[0];
  assign mid_o   = marks[1];
  assign long_o  = long_q;

endmodule

// File: rtl/event_timer_chk.sv
module event_timer_chk #(
  parameter int unsigned CNT_W     = 19,
  parameter int unsigned SHORT_CYC = 5,
  parameter int unsigned MID_CYC   = 46080
) (
  input logic clk,
  input logic rst_n,
  input logic restart_i,
  input logic short_o,
  input logic mid_o,
  input logic long_o
);

  localparam logic [CNT_W:0] LIM   = (CNT_W+1)'(1) << CNT_W;
  localparam logic [CNT_W:0] SHORT = (CNT_W+1)'(SHORT_CYC);
  localparam logic [CNT_W:0] MID   = (CNT_W+1)'(MID_CYC);

  // Independent elapsed-edge count since the last restart, saturating at 2^CNT_W.
  logic [CNT_W:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= '0;
    else if (restart_i)  age <= '0;
    else if (age != LIM) age <= age + 1'b1;
  end

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (!short_o && !mid_o && !long_o)); // R2
  AST_SHORT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(short_o) |-> (age == SHORT)); // R3
  AST_SHORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= SHORT) |-> short_o); // R3
  AST_MID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mid_o) |-> (age == MID)); // R4
  AST_MID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= MID) |-> mid_o); // R4
  AST_LONG_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(long_o) |-> (age == LIM)); // R5
  AST_LONG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (age == LIM) |-> long_o); // R5
  AST_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(short_o) || $fell(mid_o) || $fell(long_o)) |-> $past(restart_i)); // R6
  AST_LONG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    long_o |-> mid_o); // R7
  AST_MID_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    mid_o |-> short_o); // R7
  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && $past(restart_i)) |-> (!short_o && !mid_o && !long_o)); // R8

endmodule

bind event_timer event_timer_chk #(
  .CNT_W(CNT_W), .SHORT_CYC(SHORT_CYC), .MID_CYC(MID_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .restart_i(restart_i),
  .short_o(short_o), .mid_o(mid_o), .long_o(long_o)
);

// File: tb/event_timer_bench.sv
`timescale 1ns/1ps
module event_timer_bench;

  localparam int A_W = 7, A_S = 5, A_M = 40;   // mid has trailing zeros
  localparam int B_W = 6, B_S = 3, B_M = 37;   // mid with no trailing zeros

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic a_s, a_m, a_l, b_s, b_m, b_l;
  int   n_run = 0;
  int   n_fail = 0;

  always #2 clk = ~clk;

  event_timer #(.CNT_W(A_W), .SHORT_CYC(A_S), .MID_CYC(A_M)) u_event_timer (
    .clk(clk), .rst_n(rst_n), .restart_i(restart),
    .short_o(a_s), .mid_o(a_m), .long_o(a_l)
  );

  event_timer #(.CNT_W(B_W), .SHORT_CYC(B_S), .MID_CYC(B_M)) u_event_timer_b (
    .clk(clk), .rst_n(rst_n), .restart_i(restart),
    .short_o(b_s), .mid_o(b_m), .long_o(b_l)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic all_low(input string req);
    chk(req, "a short", a_s, 1'b0); chk(req, "a mid", a_m, 1'b0); chk(req, "a long", a_l, 1'b0);
    chk(req, "b short", b_s, 1'b0); chk(req, "b mid", b_m, 1'b0); chk(req, "b long", b_l, 1'b0);
  endtask

  // k = clock edges since the restarting edge; sampled at negedge.
  task automatic expect_at(input int k);
    chk("R3", "a short", a_s, k >= A_S);
    chk("R4", "a mid",   a_m, k >= A_M);
    chk("R5", "a long",  a_l, k >= (1 << A_W));
    chk("R3", "b short", b_s, k >= B_S);
    chk("R4", "b mid",   b_m, k >= B_M);
    chk("R5", "b long",  b_l, k >= (1 << B_W));
    chk("R7", "a order", (!a_l || a_m) && (!a_m || a_s), 1'b1);
    chk("R7", "b order", (!b_l || b_m) && (!b_m || b_s), 1'b1);
    if (k > (1 << A_W)) chk("R6", "a sticky past wrap", a_s && a_m && a_l, 1'b1);
    if (k > (1 << B_W)) chk("R6", "b sticky past wrap", b_s && b_m && b_l, 1'b1);
  endtask

  task automatic sweep(input int last);
    for (int k = 0; k <= last; k++) begin
      expect_at(k);
      @(negedge clk);
    end
  endtask

  task automatic do_restart;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    all_low("R1");
    rst_n = 1'b1;                // reset behaves as a restart
    sweep((1 << A_W) + 40);      // full sweep past both wraps, R1 and R3..R7

    do_restart();
    all_low("R2");
    sweep(20);

    // Restart on the edge where a short would rise: restart wins
    do_restart();
    repeat (A_S - 1) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    chk("R9", "a short at threshold edge", a_s, 1'b0);
    all_low("R9");
    sweep(A_M + 2);

    // Restart held high
    restart = 1'b1;
    for (int i = 0; i < (1 << B_W) + 8; i++) begin
      @(negedge clk);
      all_low("R8");
    end
    restart = 1'b0;
    sweep((1 << A_W) + 10);

    finish_up();
  end

endmodule